// File: doc/BRIEF.md
# PIN-Keyed Memory Word Scrambler

This block sits between a block cipher and on-chip data memory. On the store side it takes a 128-bit ciphertext word and an address and XORs the word with a 128-bit pattern. It then presents the scrambled word to memory. On the load side it takes a stored word and XORs the same pattern back out, which recovers the ciphertext for the decryption stage.

The pattern depends on the address and on a user PIN held in an internal register. A wrong PIN therefore yields a wrong ciphertext. A read-only region attribute marks code memory: such regions may only be read, and any store aimed at them is refused.

Each path has a valid-in / valid-out handshake with exactly one registered cycle of latency. Each accepted request pulse produces exactly one word. No transfer happens until a PIN has been loaded. A read and a write presented in the same cycle are both refused. Every refusal is reported on a registered error strobe that carries a cause code.

Top module: `mem_scrambler`

## Requirements
- R1: After reset, no PIN is held, `mem_wr_valid`, `rd_out_valid` and `err_valid` are low, and all data and cause outputs are zero.
- R2: A `pin_load` pulse stores `pin_in` as the active PIN from the next cycle onward; a later load replaces it. A request in the same cycle as a load still uses the PIN held before that load.
- R3: The pattern for PIN p and address a is the PIN zero-extended to 128 bits, XORed with a 128-bit mixing vector. Bit i of the mixing vector is a[(7*i) mod 16] ^ a[(13*i+1) mod 16] ^ (bit 0 of i) ^ (bit 3 of i).
- R4: An accepted write sets `mem_wr_valid` one cycle later, with `mem_wr_addr` equal to the request address and `mem_wr_data` equal to `wr_cipher` XOR the pattern of that address.
- R5: An accepted read sets `rd_out_valid` one cycle later, with `rd_out_cipher` equal to `mem_rd_data` XOR the pattern. A write followed by a read of the same address under the same PIN returns the original ciphertext.
- R6: A read under a PIN other than the one used for the write does not return the original ciphertext.
- R7: A write with `region_ro` high is refused: `mem_wr_valid` stays low and the error strobe reports cause 3. Reads with `region_ro` high are served normally.
- R8: While no PIN is held, every read or write request is refused, and the error strobe reports cause 1.
- R9: A `pin_clear` pulse invalidates the PIN and refuses any request in the same cycle. The next cycle shows zero data outputs with both valids low and the error strobe with cause 1.
- R10: A read and a write requested in the same cycle are both refused, and the error strobe reports cause 2.
- R11: Requests on consecutive cycles each produce one output word on consecutive cycles. Whenever a path's valid output is low, its data output is zero.
- R12: The cause encoding is 0 none, 1 no PIN, 2 collision, 3 read-only write. Collision takes priority over no PIN, and no PIN takes priority over a read-only write. `err_cause` is non-zero exactly when `err_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_load | input | 1 | Store `pin_in` as the active PIN |
| pin_clear | input | 1 | Invalidate the active PIN |
| pin_in | input | 32 | PIN value to load |
| region_ro | input | 1 | Current request targets a read-only region |
| wr_valid | input | 1 | Write request |
| wr_addr | input | 16 | Write word address |
| wr_cipher | input | 128 | Ciphertext to store |
| mem_wr_valid | output | 1 | Scrambled word ready for memory |
| mem_wr_addr | output | 16 | Memory write address |
| mem_wr_data | output | 128 | Scrambled word |
| rd_valid | input | 1 | Read request, stored word on `mem_rd_data` |
| rd_addr | input | 16 | Read word address |
| mem_rd_data | input | 128 | Stored word from memory |
| rd_out_valid | output | 1 | Descrambled ciphertext ready |
| rd_out_cipher | output | 128 | Descrambled ciphertext |
| err_valid | output | 1 | A request or PIN clear was refused |
| err_cause | output | 2 | Refusal cause code |

## Verification
On every cycle, the assertions check that each output word follows an acceptable request one cycle earlier, and that collisions, missing PINs and read-only writes never produce a word. They also check that a PIN clear always invalidates the PIN, that idle outputs are zero, and that the cause code agrees with the error strobe. Only the bench scenarios can show the data values: that the pattern matches the formula, that a store and a load under the same PIN round-trip, and that a wrong PIN does not. The same applies to the rule that a request issued during a PIN load uses the old PIN.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int DEF_DATA_W = 128;
  localparam int DEF_ADDR_W = 16;
  localparam int DEF_PIN_W  = 32;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_NOPIN   = 2'd1,
    CAUSE_COLLIDE = 2'd2,
    CAUSE_RO_WR   = 2'd3
  } err_cause_e;
endpackage

// File: rtl/scr_pin_reg.sv
module scr_pin_reg #(
  parameter int PIN_W = scr_pkg::DEF_PIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_load,
  input  logic             pin_clear,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] pin_q,
  output logic             pin_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '0;
      pin_ok <= 1'b0;
    end else if (pin_clear) begin
      pin_q  <= '0;
      pin_ok <= 1'b0;
    end else if (pin_load) begin
      pin_q  <= pin_in;
      pin_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/scr_pattern_gen.sv
module scr_pattern_gen #(
  parameter int DATA_W = scr_pkg::DEF_DATA_W,
  parameter int ADDR_W = scr_pkg::DEF_ADDR_W,
  parameter int PIN_W  = scr_pkg::DEF_PIN_W
) (
  input  logic [PIN_W-1:0]  pin,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] pattern
);
  localparam int PAD_W = DATA_W - PIN_W;

  function automatic logic [DATA_W-1:0] mix_addr(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) begin
      logic tap_c;
      tap_c = 1'(i) ^ 1'(i >> 3);
      m[i] = a[(i * 7) % ADDR_W] ^ a[(i * 13 + 1) % ADDR_W] ^ tap_c;
    end
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] make_pattern(input logic [PIN_W-1:0] p,
                                                     input logic [ADDR_W-1:0] a);
    return {{PAD_W{1'b0}}, p} ^ mix_addr(a);
  endfunction

  assign pattern = make_pattern(pin, addr);
endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl (
  input  logic                  pin_ok,
  input  logic                  pin_clear,
  input  logic                  region_ro,
  input  logic                  wr_valid,
  input  logic                  rd_valid,
  output logic                  wr_go,
  output logic                  rd_go,
  output logic                  err_evt,
  output scr_pkg::err_cause_e   err_code
);
  import scr_pkg::*;
  logic usable, collide, any_req, ro_wr;

  always_comb begin
    usable  = pin_ok && !pin_clear;
    collide = wr_valid && rd_valid;
    any_req = wr_valid || rd_valid;
    ro_wr   = wr_valid && !rd_valid && region_ro;
    wr_go   = wr_valid && !rd_valid && usable && !region_ro;
    rd_go   = rd_valid && !wr_valid && usable;
    err_evt = 1'b0;
    err_code = CAUSE_NONE;
    if (collide) begin
      err_evt  = 1'b1;
      err_code = CAUSE_COLLIDE;
    end else if (pin_clear || (any_req && !usable)) begin
      err_evt  = 1'b1;
      err_code = CAUSE_NOPIN;
    end else if (ro_wr) begin
      err_evt  = 1'b1;
      err_code = CAUSE_RO_WR;
    end
  end
endmodule

// File: rtl/scr_lane.sv
module scr_lane #(
  parameter int DATA_W = scr_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] word_in,
  input  logic [DATA_W-1:0] pattern,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= go;
      out_word  <= go ? (word_in ^ pattern) : '0;
    end
  end
endmodule

// File: rtl/mem_scrambler.sv
module mem_scrambler #(
  parameter int DATA_W = scr_pkg::DEF_DATA_W,
  parameter int ADDR_W = scr_pkg::DEF_ADDR_W,
  parameter int PIN_W  = scr_pkg::DEF_PIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_load,
  input  logic              pin_clear,
  input  logic [PIN_W-1:0]  pin_in,
  input  logic              region_ro,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_cipher,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              rd_out_valid,
  output logic [DATA_W-1:0] rd_out_cipher,
  output logic              err_valid,
  output logic [1:0]        err_cause
);
  import scr_pkg::*;
  localparam int N_LANES = 2;

  logic [PIN_W-1:0]  pin_q;
  logic              pin_ok;
  logic              wr_go, rd_go, err_evt;
  err_cause_e        err_code;
  logic [ADDR_W-1:0] lane_addr [N_LANES];
  logic [DATA_W-1:0] lane_in   [N_LANES];
  logic [DATA_W-1:0] lane_pat  [N_LANES];
  logic [DATA_W-1:0] lane_out  [N_LANES];
  logic              lane_go   [N_LANES];
  logic              lane_vld  [N_LANES];

  scr_pin_reg #(.PIN_W(PIN_W)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_load(pin_load), .pin_clear(pin_clear),
    .pin_in(pin_in), .pin_q(pin_q), .pin_ok(pin_ok)
  );

  scr_ctrl u_ctrl (
    .pin_ok(pin_ok), .pin_clear(pin_clear), .region_ro(region_ro),
    .wr_valid(wr_valid), .rd_valid(rd_valid), .wr_go(wr_go), .rd_go(rd_go),
    .err_evt(err_evt), .err_code(err_code)
  );

  assign lane_addr[0] = wr_addr;
  assign lane_in[0]   = wr_cipher;
  assign lane_go[0]   = wr_go;
  assign lane_addr[1] = rd_addr;
  assign lane_in[1]   = mem_rd_data;
  assign lane_go[1]   = rd_go;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    scr_pattern_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_pat (
      .pin(pin_q), .addr(lane_addr[g]), .pattern(lane_pat[g])
    );
    scr_lane #(.DATA_W(DATA_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .go(lane_go[g]), .word_in(lane_in[g]),
      .pattern(lane_pat[g]), .out_valid(lane_vld[g]), .out_word(lane_out[g])
    );
  end

  assign mem_wr_valid  = lane_vld[0];
  assign mem_wr_data   = lane_out[0];
  assign rd_out_valid  = lane_vld[1];
  assign rd_out_cipher = lane_out[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_wr_addr <= '0;
      err_valid   <= 1'b0;
      err_cause   <= 2'd0;
    end else begin
      mem_wr_addr <= wr_go ? wr_addr : '0;
      err_valid   <= err_evt;
      err_cause   <= err_evt ? err_code : CAUSE_NONE;
    end
  end
endmodule

// File: rtl/mem_scrambler_chk.sv
module mem_scrambler_chk #(
  parameter int DATA_W = 128,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pin_ok,
  input logic              pin_clear,
  input logic              region_ro,
  input logic              wr_valid,
  input logic              rd_valid,
  input logic              mem_wr_valid,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              rd_out_valid,
  input logic [DATA_W-1:0] rd_out_cipher,
  input logic              err_valid,
  input logic [1:0]        err_cause
);
  // R4
  wr_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> $past(wr_valid && !rd_valid && !region_ro && pin_ok && !pin_clear));
  // R5
  rd_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out_valid |-> $past(rd_valid && !wr_valid && pin_ok && !pin_clear));
  // R10
  collide_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && rd_valid) |=> (!mem_wr_valid && !rd_out_valid && err_valid && err_cause == 2'd2));
  // R7
  ro_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && region_ro) |=> (!mem_wr_valid && err_valid));
  // R8
  nopin_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_valid || rd_valid) && !pin_ok) |=> (!mem_wr_valid && !rd_out_valid && err_valid));
  // R9
  clear_drops_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_clear |=> (!pin_ok && err_valid && !mem_wr_valid && !rd_out_valid));
  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_valid |-> (mem_wr_data == '0 && mem_wr_addr == '0)) and
    (!rd_out_valid |-> rd_out_cipher == '0));
  // R12
  cause_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid == (err_cause != 2'd0));
endmodule

bind mem_scrambler mem_scrambler_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_ok(pin_ok), .pin_clear(pin_clear),
  .region_ro(region_ro), .wr_valid(wr_valid), .rd_valid(rd_valid),
  .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
  .rd_out_valid(rd_out_valid), .rd_out_cipher(rd_out_cipher),
  .err_valid(err_valid), .err_cause(err_cause)
);

// File: tb/mem_scrambler_test.sv
module mem_scrambler_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_load = 0, pin_clear = 0, region_ro = 0, wr_valid = 0, rd_valid = 0;
  logic [31:0]  pin_in = '0;
  logic [15:0]  wr_addr = '0, rd_addr = '0, mem_wr_addr;
  logic [127:0] wr_cipher = '0, mem_rd_data = '0, mem_wr_data, rd_out_cipher;
  logic mem_wr_valid, rd_out_valid, err_valid;
  logic [1:0] err_cause;
  int checks = 0, errors = 0;
  logic [127:0] slot_data [16];
  logic [127:0] slot_orig [16];
  logic [31:0]  slot_pin  [16];
  logic         slot_used [16];

  always #2 clk = ~clk;

  mem_scrambler uut (.*);

  function automatic logic [127:0] exp_pat(input logic [31:0] p, input logic [15:0] a);
    logic [127:0] v;
    for (int i = 0; i < 128; i++)
      v[i] = (a[(7 * i) % 16] != a[(13 * i + 1) % 16]) != ((i % 2) != ((i / 8) % 2));
    return v ^ {96'd0, p};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic ro,
                      input logic [15:0] wa, input logic [127:0] wd,
                      input logic [15:0] ra, input logic [127:0] rdd,
                      input logic pl, input logic pc, input logic [31:0] pd);
    wr_valid = w; rd_valid = r; region_ro = ro; wr_addr = wa; wr_cipher = wd;
    rd_addr = ra; mem_rd_data = rdd; pin_load = pl; pin_clear = pc; pin_in = pd;
    @(posedge clk); @(negedge clk);
    wr_valid = 0; rd_valid = 0; pin_load = 0; pin_clear = 0; region_ro = 0;
  endtask

  task automatic load_pin(input logic [31:0] p);
    step(0, 0, 0, '0, '0, '0, '0, 1, 0, p);
  endtask

  task automatic err_is(input int c, input string req);
    chk(err_valid && err_cause == 2'(c), req, {126'd0, err_cause}, 128'(c));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [127:0] c0, got, scr;
    void'($urandom(32'd7311));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!mem_wr_valid && !rd_out_valid && !err_valid && mem_wr_data == 0 && rd_out_cipher == 0 && err_cause == 0,
        "R1 reset outputs", mem_wr_data, '0);

    // R8 write and read before any PIN
    step(1, 0, 0, 16'h0010, 128'h1234, '0, '0, 0, 0, '0);
    chk(!mem_wr_valid, "R8 write blocked", {127'd0, mem_wr_valid}, '0);
    err_is(1, "R8 cause");
    step(0, 1, 0, '0, '0, 16'h0010, 128'h55, 0, 0, '0);
    chk(!rd_out_valid, "R8 read blocked", {127'd0, rd_out_valid}, '0);

    // R3 pattern with zero PIN and zero data
    load_pin(32'h0);
    step(1, 0, 0, 16'h0000, '0, '0, '0, 0, 0, '0);
    chk(mem_wr_valid && mem_wr_data == exp_pat(0, 0), "R3 pattern a=0", mem_wr_data, exp_pat(0, 0));
    step(1, 0, 0, 16'hBEEF, '0, '0, '0, 0, 0, '0);
    chk(mem_wr_data == exp_pat(0, 16'hBEEF), "R3 pattern a=BEEF", mem_wr_data, exp_pat(0, 16'hBEEF));

    // R2 R4 load PIN and write
    load_pin(32'hC0DE_1234);
    c0 = {$urandom, $urandom, $urandom, $urandom};
    step(1, 0, 0, 16'h0042, c0, '0, '0, 0, 0, '0);
    scr = mem_wr_data;
    chk(mem_wr_valid && mem_wr_addr == 16'h0042 && scr == (c0 ^ exp_pat(32'hC0DE_1234, 16'h0042)),
        "R4 write scrambled", scr, c0 ^ exp_pat(32'hC0DE_1234, 16'h0042));
    chk(!err_valid, "R4 no error", {127'd0, err_valid}, '0);

    // R5 round trip
    step(0, 1, 0, '0, '0, 16'h0042, scr, 0, 0, '0);
    chk(rd_out_valid && rd_out_cipher == c0, "R5 round trip", rd_out_cipher, c0);

    // R6 wrong PIN
    load_pin(32'hC0DE_1235);
    step(0, 1, 0, '0, '0, 16'h0042, scr, 0, 0, '0);
    chk(rd_out_valid && rd_out_cipher != c0, "R6 wrong PIN differs", rd_out_cipher, c0);

    // R2 load in same cycle as write uses old PIN
    step(1, 0, 0, 16'h0007, c0, '0, '0, 1, 0, 32'hC0DE_1234);
    chk(mem_wr_data == (c0 ^ exp_pat(32'hC0DE_1235, 16'h0007)), "R2 old PIN used", mem_wr_data,
        c0 ^ exp_pat(32'hC0DE_1235, 16'h0007));
    step(0, 1, 0, '0, '0, 16'h0042, scr, 0, 0, '0);
    chk(rd_out_cipher == c0, "R2 new PIN active", rd_out_cipher, c0);

    // R7 read-only region
    step(0, 1, 1, '0, '0, 16'h0042, scr, 0, 0, '0);
    chk(rd_out_valid && rd_out_cipher == c0, "R7 read in RO served", rd_out_cipher, c0);
    step(1, 0, 1, 16'h0042, c0, '0, '0, 0, 0, '0);
    chk(!mem_wr_valid && mem_wr_data == 0, "R7 RO write refused", mem_wr_data, '0);
    err_is(3, "R7 cause");

    // R10 R12 collision
    step(1, 1, 0, 16'h1, c0, 16'h1, scr, 0, 0, '0);
    chk(!mem_wr_valid && !rd_out_valid, "R10 collision none", {126'd0, mem_wr_valid, rd_out_valid}, '0);
    err_is(2, "R10 cause");

    // R11 back-to-back writes and idle zero
    for (int k = 0; k < 4; k++) begin
      logic [127:0] d;
      d = {$urandom, $urandom, $urandom, $urandom};
      step(1, 0, 0, 16'(k * 3), d, '0, '0, 0, 0, '0);
      chk(mem_wr_valid && mem_wr_data == (d ^ exp_pat(32'hC0DE_1234, 16'(k * 3))),
          "R11 back-to-back", mem_wr_data, d ^ exp_pat(32'hC0DE_1234, 16'(k * 3)));
    end
    step(0, 0, 0, '0, '0, '0, '0, 0, 0, '0);
    chk(!mem_wr_valid && mem_wr_data == 0 && rd_out_cipher == 0 && !err_valid, "R11 idle zero", mem_wr_data, '0);

    // R9 clear with request in the same cycle
    step(1, 0, 0, 16'h9, c0, '0, '0, 0, 1, '0);
    chk(!mem_wr_valid && mem_wr_data == 0, "R9 clear blocks", mem_wr_data, '0);
    err_is(1, "R9 cause");
    step(1, 0, 0, 16'h9, c0, '0, '0, 0, 0, '0);
    chk(!mem_wr_valid, "R9 stays cleared", {127'd0, mem_wr_valid}, '0);
    // R12 collision outranks missing PIN
    step(1, 1, 0, 16'h9, c0, 16'h9, c0, 0, 0, '0);
    err_is(2, "R12 priority");

    // random traffic
    for (int s = 0; s < 16; s++) slot_used[s] = 0;
    load_pin(32'hA5A5_0001);
    begin
      logic [31:0] cur;
      cur = 32'hA5A5_0001;
      for (int n = 0; n < 300; n++) begin
        int op, s;
        logic [15:0] a;
        op = $urandom_range(0, 9);
        s  = $urandom_range(0, 15);
        a  = {12'h3C1, 4'(s)};
        if (op == 0) begin
          cur = ($urandom_range(0, 1) == 0) ? 32'hA5A5_0001 : $urandom;
          load_pin(cur);
        end else if (op < 6) begin
          got = {$urandom, $urandom, $urandom, $urandom};
          step(1, 0, 0, a, got, '0, '0, 0, 0, '0);
          chk(mem_wr_valid && mem_wr_data == (got ^ exp_pat(cur, a)), "R4 random write",
              mem_wr_data, got ^ exp_pat(cur, a));
          slot_data[s] = mem_wr_data; slot_orig[s] = got; slot_pin[s] = cur; slot_used[s] = 1;
        end else if (slot_used[s]) begin
          step(0, 1, $urandom_range(0, 1) == 1, '0, '0, a, slot_data[s], 0, 0, '0);
          if (slot_pin[s] == cur)
            chk(rd_out_valid && rd_out_cipher == slot_orig[s], "R5 random round trip", rd_out_cipher, slot_orig[s]);
          else
            chk(rd_out_valid && rd_out_cipher != slot_orig[s], "R6 random wrong PIN", rd_out_cipher, slot_orig[s]);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule